// File: doc/BRIEF.md
# SPI Command-Decoding Board Controller

This block is an SPI slave for a board-management device. Each chip-select frame opens with a one-byte opcode. The opcode picks the frame format that follows.

The block holds an 8-bit configuration word that drives board pins: four indicator lights, a fan enable and the control lines of a parallel flash. It also drives a ninth, separate indicator output that only two dedicated opcodes can reach. Other opcodes bridge serial bytes onto an 8-bit parallel flash-style data bus. Write frames produce write strobes. Read frames fetch bytes with read strobes and return them on MISO. The fast-read form first takes a 24-bit address.

The SPI pins are asynchronous to the system clock. They pass through two-flop synchronisers, and SCK edges are found in the system clock domain, so SCK must be several times slower than the system clock. Mode 0 is used: SCK idles low, data is sampled on the rising edge and shifted on the falling edge, and bytes travel MSB first.

Top module: `spi_board_ctrl`

## Requirements
- R1: After reset, cfg_out is 0x8F, led_n is 1, miso is 0, and bus_wr and bus_rd are low.
- R2: Bits are sampled on rising SCK edges while cs_n is low, 8 per byte, MSB first. The first complete byte of a frame is its opcode, and MISO carries 0 during the opcode byte.
- R3: Opcode 0x09 loads each following complete byte into cfg_out. The field layout is: bit0-3 lights (low = on), bit4 fan, bit5 address latch, bit6 command latch, bit7 flash enable (low = on).
- R4: Opcode 0x08 writes each following data byte once the next byte completes, as a one-cycle bus_wr pulse with the byte on bus_wdata. The final byte of the frame (the idle byte) is never written.
- R5: Opcode 0x0A skips one dummy byte. A one-cycle bus_rd pulse is issued at the end of the dummy byte and at the end of each later byte. Byte k after the dummy is returned on MISO MSB first, and its value is the bus_rdata captured during the k-th strobe. bus_wr and bus_rd are never high together.
- R6: Opcode 0x0B takes three address bytes, most significant first, then one dummy byte, then reads as in R5. bus_addr holds the address during the first strobe and rises by one for each later strobe.
- R7: Opcode 0x0C drives led_n to 0 and opcode 0x0D drives it to 1. Any further bytes in those frames are ignored, and cfg_out is unaffected.
- R8: A rise of cs_n ends the frame. A partly received byte is discarded, and the next frame starts with an opcode. With cs_n high, no strobe is issued and neither cfg_out nor led_n changes.
- R9: Any other opcode makes the rest of the frame ignored: no strobes, no change to cfg_out or led_n, and MISO stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | SPI data in |
| cs_n | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data out |
| cfg_out | output | 8 | Configuration word driving board pins |
| led_n | output | 1 | Separate indicator, active low |
| bus_wdata | output | 8 | Parallel write data |
| bus_wr | output | 1 | Write strobe, one cycle |
| bus_rdata | input | 8 | Parallel read data, sampled while bus_rd is high |
| bus_rd | output | 1 | Read strobe, one cycle |
| bus_addr | output | 24 | Fast-read address |

## Verification
The bench sends frames whose closing idle byte carries a distinctive value. A design without the one-byte write delay would show an extra bus write. It also cuts frames off mid-byte and then sends a fresh configuration frame. A decoder that kept the stale bits would load a shifted byte or treat data as an opcode. The asymmetric configuration value 0x01 would read back as 0x80 if bit order were reversed. Read checks match each returned byte against the strobe that fetched it, so a prefetch off by one byte, or an address that fails to step, shows up as a data or address mismatch.

// File: rtl/spi_board_ctrl_pkg.sv
package spi_board_ctrl_pkg;
    localparam logic [7:0] OP_WRITE = 8'h08;
    localparam logic [7:0] OP_CFG   = 8'h09;
    localparam logic [7:0] OP_READ  = 8'h0A;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_LON   = 8'h0C;
    localparam logic [7:0] OP_LOFF  = 8'h0D;

    typedef enum logic [2:0] {
        ST_OPC, ST_CFG, ST_WRITE, ST_RDUMMY, ST_ADDR, ST_FDUMMY, ST_READ, ST_SKIP
    } dec_st_e;
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
    parameter int WIDTH   = 3,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg_q[s] <= RST_VAL;
            else if (s == 0) stg_q[s] <= async_in;
            else             stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= stg_q[STAGES-1];
    end

    assign level = stg_q[STAGES-1];
    assign rise  = stg_q[STAGES-1] & ~prev_q;
    assign fall  = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/bsc_shifter.sv
module bsc_shifter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi_s,
    input  logic [BW-1:0] tx_byte,
    output logic          byte_vld,
    output logic [BW-1:0] byte_data,
    output logic          miso
);
    localparam int CW = $clog2(BW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [BW-2:0] rx;
        logic [BW-2:0] tx;
        logic          out;
        logic          vld;
        logic [BW-1:0] data;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d = q;
        d.vld = 1'b0;
        if (!cs_act) begin
            d.cnt = '0;
            d.tx  = '0;
            d.out = 1'b0;
        end else begin
            if (sck_rise) begin
                d.rx  = {q.rx[BW-3:0], mosi_s};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(BW-1)) begin
                    d.vld  = 1'b1;
                    d.data = {q.rx, mosi_s};
                end
            end
            if (sck_fall) begin
                if (q.cnt == '0) {d.out, d.tx} = tx_byte;
                else             {d.out, d.tx} = {q.tx, 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_vld  = q.vld;
    assign byte_data = q.data;
    assign miso      = q.out;
endmodule

// File: rtl/bsc_decoder.sv
module bsc_decoder
    import spi_board_ctrl_pkg::*;
#(
    parameter int BW     = 8,
    parameter int ADDR_W = 24,
    parameter logic [BW-1:0] CFG_RST = 8'h8F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_vld,
    input  logic [BW-1:0]     byte_data,
    input  logic [BW-1:0]     bus_rdata,
    output logic [BW-1:0]     tx_byte,
    output logic [BW-1:0]     cfg_out,
    output logic              led_n,
    output logic [BW-1:0]     bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr
);
    localparam int ABYTES = ADDR_W / BW;
    localparam int IW     = (ABYTES > 1) ? $clog2(ABYTES) : 1;

    typedef struct packed {
        dec_st_e           st;
        logic [IW-1:0]     idx;
        logic              fast;
        logic [BW-1:0]     hold;
        logic              hold_vld;
        logic [BW-1:0]     cfg;
        logic              led_n;
        logic [ADDR_W-1:0] addr;
        logic [BW-1:0]     tx;
        logic              wr;
        logic [BW-1:0]     wdata;
        logic              rd;
    } dec_t;

    dec_t d, q;

    always_comb begin
        d = q;
        d.wr = 1'b0;
        d.rd = 1'b0;
        if (q.rd) begin
            d.tx = bus_rdata;
            if (q.fast) d.addr = q.addr + 1'b1;
        end
        if (!cs_act) begin
            d.st       = ST_OPC;
            d.idx      = '0;
            d.fast     = 1'b0;
            d.hold_vld = 1'b0;
            d.tx       = '0;
        end else if (byte_vld) begin
            unique case (q.st)
                ST_OPC: begin
                    d.tx = '0;
                    case (byte_data)
                        OP_WRITE: begin d.st = ST_WRITE; d.hold_vld = 1'b0; end
                        OP_CFG:   d.st = ST_CFG;
                        OP_READ:  begin d.st = ST_RDUMMY; d.fast = 1'b0; end
                        OP_FAST:  begin d.st = ST_ADDR; d.fast = 1'b1; d.idx = '0; end
                        OP_LON:   begin d.led_n = 1'b0; d.st = ST_SKIP; end
                        OP_LOFF:  begin d.led_n = 1'b1; d.st = ST_SKIP; end
                        default:  d.st = ST_SKIP;
                    endcase
                end
                ST_CFG: d.cfg = byte_data;
                ST_WRITE: begin
                    if (q.hold_vld) begin
                        d.wr    = 1'b1;
                        d.wdata = q.hold;
                    end
                    d.hold     = byte_data;
                    d.hold_vld = 1'b1;
                end
                ST_ADDR: begin
                    d.addr = {q.addr[ADDR_W-BW-1:0], byte_data};
                    d.idx  = q.idx + 1'b1;
                    if (q.idx == IW'(ABYTES-1)) d.st = ST_FDUMMY;
                end
                ST_RDUMMY, ST_FDUMMY, ST_READ: begin
                    d.rd = 1'b1;
                    d.st = ST_READ;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_OPC;
            q.cfg   <= CFG_RST;
            q.led_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_byte   = q.tx;
    assign cfg_out   = q.cfg;
    assign led_n     = q.led_n;
    assign bus_wdata = q.wdata;
    assign bus_wr    = q.wr;
    assign bus_rd    = q.rd;
    assign bus_addr  = q.addr;
endmodule

// File: rtl/spi_board_ctrl.sv
module spi_board_ctrl #(
    parameter int BW          = 8,
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter logic [BW-1:0] CFG_RST = 8'h8F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              miso,
    output logic [BW-1:0]     cfg_out,
    output logic              led_n,
    output logic [BW-1:0]     bus_wdata,
    output logic              bus_wr,
    input  logic [BW-1:0]     bus_rdata,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr
);
    logic [2:0]    lvl, rise, fall;
    logic          byte_vld;
    logic [BW-1:0] byte_data, tx_byte;

    bsc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({cs_n, mosi, sck}),
        .level(lvl), .rise(rise), .fall(fall)
    );

    bsc_shifter #(.BW(BW)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_act(~lvl[2]),
        .sck_rise(rise[0]), .sck_fall(fall[0]), .mosi_s(lvl[1]),
        .tx_byte(tx_byte), .byte_vld(byte_vld), .byte_data(byte_data), .miso(miso)
    );

    bsc_decoder #(.BW(BW), .ADDR_W(ADDR_W), .CFG_RST(CFG_RST)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_act(~lvl[2]),
        .byte_vld(byte_vld), .byte_data(byte_data), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .cfg_out(cfg_out), .led_n(led_n),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr)
    );
endmodule

// File: rtl/spi_board_ctrl_chk.sv
module spi_board_ctrl_chk #(
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [BW-1:0] cfg_out,
    input logic          led_n
);
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr);

    p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd);

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
        |-> (!bus_wr && !bus_rd && $stable(cfg_out) && $stable(led_n)));
endmodule

bind spi_board_ctrl spi_board_ctrl_chk #(.BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .cfg_out(cfg_out), .led_n(led_n)
);

// File: tb/spi_board_ctrl_test.sv
module spi_board_ctrl_test;
    localparam int HALF = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic miso, led_n, bus_wr, bus_rd;
    logic [7:0] cfg_out, bus_wdata, bus_rdata;
    logic [23:0] bus_addr;

    int errors = 0, checks = 0, wn = 0, rn = 0;
    logic [7:0]  wlog [256];
    logic [23:0] alog [256];
    logic [7:0]  cfg_exp = 8'h8F;
    logic        led_exp = 1'b1;
    bit          done = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(int n);
        return 8'(n * 29 + 59) ^ 8'(n >> 3);
    endfunction

    assign bus_rdata = pat(rn);

    spi_board_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .miso(miso), .cfg_out(cfg_out), .led_n(led_n), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_addr(bus_addr)
    );

    always @(posedge clk) begin
        if (bus_wr) begin wlog[wn[7:0]] <= bus_wdata; wn <= wn + 1; end
        if (bus_rd) begin alog[rn[7:0]] <= bus_addr; rn <= rn + 1; end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic bits(int n);
        for (int b = 0; b < n; b++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic fbeg;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic fend;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_cfg(int n, int tagn);
        logic [7:0] rx, v;
        fbeg();
        xfer(8'h09, rx);
        for (int i = 0; i < n; i++) begin
            v = 8'($urandom());
            xfer(v, rx);
            cfg_exp = v;
        end
        fend();
        chk(cfg_out == cfg_exp, (tagn == 2) ? "R2 bit order" : "R3 cfg load", cfg_out, cfg_exp);
    endtask

    task automatic do_write(int n);
        logic [7:0] rx;
        logic [7:0] vals [16];
        int w0 = wn;
        fbeg();
        xfer(8'h08, rx);
        for (int i = 0; i < n; i++) begin vals[i] = 8'($urandom()); xfer(vals[i], rx); end
        xfer(8'hEE, rx);
        fend();
        chk(wn - w0 == n, "R4 write count", wn - w0, n);
        for (int i = 0; i < n; i++)
            chk(wlog[8'(w0 + i)] == vals[i], "R4 write data", wlog[8'(w0 + i)], vals[i]);
    endtask

    task automatic do_read(bit fast, logic [23:0] a, int n);
        logic [7:0] rx;
        int r0 = rn;
        fbeg();
        xfer(fast ? 8'h0B : 8'h0A, rx);
        chk(rx == 8'h00, "R2 miso opcode", rx, 0);
        if (fast) begin
            xfer(a[23:16], rx); xfer(a[15:8], rx); xfer(a[7:0], rx);
        end
        xfer(8'h00, rx);
        chk(rx == 8'h00, "R5 miso dummy", rx, 0);
        for (int i = 0; i < n; i++) begin
            xfer(8'($urandom()), rx);
            chk(rx == pat(r0 + i), fast ? "R6 fast data" : "R5 read data", rx, pat(r0 + i));
        end
        fend();
        chk(rn - r0 == n + 1, "R5 strobe count", rn - r0, n + 1);
        if (fast)
            for (int i = 0; i <= n; i++)
                chk(alog[8'(r0 + i)] == a + 24'(i), "R6 address", alog[8'(r0 + i)], a + 24'(i));
    endtask

    task automatic do_led(bit on, int extra);
        logic [7:0] rx;
        fbeg();
        xfer(on ? 8'h0C : 8'h0D, rx);
        for (int i = 0; i < extra; i++) xfer(8'h09, rx);
        fend();
        led_exp = ~on;
        chk(led_n == led_exp, "R7 led", led_n, led_exp);
        chk(cfg_out == cfg_exp, "R7 cfg untouched", cfg_out, cfg_exp);
    endtask

    task automatic do_unknown(logic [7:0] op, int n);
        logic [7:0] rx;
        int w0 = wn, r0 = rn;
        fbeg();
        xfer(op, rx);
        for (int i = 0; i < n; i++) begin
            xfer(8'h0C, rx);
            chk(rx == 8'h00, "R9 miso zero", rx, 0);
        end
        fend();
        chk(wn == w0 && rn == r0, "R9 no strobes", wn + rn, w0 + r0);
        chk(cfg_out == cfg_exp && led_n == led_exp, "R9 state kept", {led_n, cfg_out}, {led_exp, cfg_exp});
    endtask

    initial begin
        logic [7:0] rx;
        int w0;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cfg_out == 8'h8F, "R1 cfg reset", cfg_out, 8'h8F);
        chk(led_n == 1'b1 && miso == 1'b0, "R1 led/miso reset", {led_n, miso}, 2'b10);
        chk(wn == 0 && rn == 0, "R1 no strobes", wn + rn, 0);

        // R2: asymmetric value exposes bit order
        fbeg(); xfer(8'h09, rx); xfer(8'h01, rx); fend();
        cfg_exp = 8'h01;
        chk(cfg_out == 8'h01, "R2 msb first", cfg_out, 8'h01);
        do_cfg(3, 3);
        do_write(3);
        do_write(0);
        do_read(1'b0, 24'h0, 3);
        do_read(1'b1, 24'h1234FE, 4);
        do_led(1'b1, 1);
        do_led(1'b0, 0);

        // R8: abort mid-byte, then a clean frame
        fbeg(); xfer(8'h09, rx); bits(4); fend();
        chk(cfg_out == cfg_exp, "R8 partial discarded", cfg_out, cfg_exp);
        fbeg(); xfer(8'h09, rx); xfer(8'hC3, rx); fend();
        cfg_exp = 8'hC3;
        chk(cfg_out == 8'hC3, "R8 restart at opcode", cfg_out, 8'hC3);
        w0 = wn;
        fbeg(); xfer(8'h08, rx); xfer(8'hA5, rx); xfer(8'h5A, rx); bits(3); fend();
        chk(wn - w0 == 1 && wlog[8'(w0)] == 8'hA5, "R8 write abort", wn - w0, 1);

        do_unknown(8'h3C, 2);
        do_unknown(8'h00, 1);

        for (int k = 0; k < 24; k++) begin
            case ($urandom_range(0, 5))
                0: do_cfg($urandom_range(1, 3), 3);
                1: do_write($urandom_range(1, 5));
                2: do_read(1'b0, 24'h0, $urandom_range(1, 4));
                3: do_read(1'b1, 24'($urandom()), $urandom_range(1, 4));
                4: do_led(1'($urandom()), $urandom_range(0, 2));
                default: do_unknown(8'($urandom_range(16, 255)), $urandom_range(0, 2));
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule